// File: doc/BRIEF.md
# Big-Endian Load/Store Data Formatter

This block sits between a 32-bit data memory port and a 16-entry, 32-bit register file. It takes one access request at a time and moves data between the two. An access can be a byte, a halfword, a word or a doubleword. On a store, it reads the source register, places the data on the byte lanes the address selects, and drives matching byte enables. On a load, it takes the addressed lanes from the returned word, sign-extends or zero-extends them to 32 bits, and hands the result to the register writeback port.

Memory is big-endian: the byte at the lowest address is the most significant byte. A per-request swap mode reverses the byte order inside the accessed element, so that little-endian data can be moved. A doubleword uses an even/odd register pair and takes two memory beats. A request that is misaligned, or that names an illegal register pair, is flagged and rejected before any memory beat is issued. Both the memory side and the writeback side use valid/ready handshakes, and the block waits while the far side holds ready low.

Top module: `ldst_fmt`

## Requirements
- R1: After reset, req_ready is 1, and mem_valid, rf_wr_valid, done, misaligned and illegal are all 0.
- R2: Size code 0 selects a byte, 1 a halfword, 2 a word and 3 a doubleword. For a byte load at address offset k, the byte taken is mem_rdata bits [31-8k:24-8k]. It is sign-extended when req_signed is 1 and zero-extended when req_signed is 0.
- R3: A halfword load takes mem_rdata[31:16] at offset 0 and mem_rdata[15:0] at offset 2. It is extended according to req_signed in the same way as a byte.
- R4: A word load writes mem_rdata unchanged to the target register.
- R5: When req_swap is 1, the byte order inside a halfword or a word is reversed on both loads and stores. A single byte is not affected.
- R6: A byte store copies the register's low byte onto every lane and asserts one enable; mem_be bit i covers bits 8i+7:8i, so offset k asserts mem_be[3-k]. A halfword store drives enables 4'b1100 at offset 0 and 4'b0011 at offset 2. Word and doubleword beats drive 4'b1111.
- R7: A doubleword takes two beats, at the request address and then at the address plus 4. In big-endian mode the first beat belongs to the odd register (reg+1) and the second beat to the even register. In swap mode the first beat belongs to the even register, with its bytes reversed.
- R8: A doubleword request with an odd register number or register 14 pulses illegal for one cycle after acceptance. It produces no memory beat, no writeback and no done.
- R9: A halfword at an odd address, or a word or doubleword whose address bits [1:0] are not zero, pulses misaligned for one cycle after acceptance. It produces no memory beat, no writeback and no done.
- R10: While mem_valid is high and mem_ready is low, the memory outputs hold steady. While rf_wr_valid is high and rf_wr_ready is low, the writeback outputs hold steady. Each beat completes in exactly one handshake.
- R11: done pulses for exactly one cycle, in the cycle after the final handshake of an accepted legal request. That handshake is the last memory beat for a store and the last writeback for a load.
- R12: req_ready is 1 only when no access is in progress, so only one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend byte and halfword loads |
| req_swap | input | 1 | Reverse byte order inside the element |
| req_addr | input | 32 | Byte address of the access |
| req_reg | input | 4 | Register index (even register for a doubleword) |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts the beat; load data is valid in the same cycle |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| rf_rd_idx | output | 4 | Register file read index for store data |
| rf_rd_data | input | 32 | Register file read data |
| rf_wr_valid | output | 1 | Writeback valid |
| rf_wr_ready | input | 1 | Register file accepts the writeback |
| rf_wr_idx | output | 4 | Writeback register index |
| rf_wr_data | output | 32 | Writeback data |
| done | output | 1 | One-cycle pulse when an access completes |
| misaligned | output | 1 | One-cycle pulse for a rejected misaligned request |
| illegal | output | 1 | One-cycle pulse for a rejected illegal register pair |

## Verification
A wrong beat counter or pair-select bit shows up at once. The two halves of a doubleword land in swapped registers, or the second beat's address fails to step by 4, and both are visible in the cycles of that same access. A wrong lane or extension choice corrupts the very next writeback value or byte enable, so a single access with a known memory word exposes it. A state that leaves its loop early or late shows up within one request: the number of memory handshakes, writebacks or done pulses differs from one or two. A rejected request that still reaches memory shows up as a handshake one cycle after acceptance.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_WB   = 2'd2
  } fsm_e;

  typedef struct packed {
    logic      store;
    acc_size_e size;
    logic      sgn;
    logic      swap;
  } acc_mode_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_CNT = 16,
  parameter int LANES   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  input  logic                       req_store_i,
  input  acc_size_e                  req_size_i,
  input  logic                       req_sgn_i,
  input  logic                       req_swap_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [$clog2(REG_CNT)-1:0] req_reg_i,
  input  logic                       mem_ready_i,
  input  logic                       wb_ready_i,
  output logic                       req_ready_o,
  output logic                       mem_valid_o,
  output logic                       wb_valid_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [$clog2(REG_CNT)-1:0] reg_idx_o,
  output acc_mode_t                  mode_o,
  output logic [$clog2(LANES)-1:0]   off_o,
  output logic                       ld_cap_o,
  output logic                       done_o,
  output logic                       misaligned_o,
  output logic                       illegal_o
);

  localparam int IDX_W = $clog2(REG_CNT);
  localparam int OFF_W = $clog2(LANES);
  localparam logic [IDX_W-1:0] TOP_PAIR = IDX_W'(REG_CNT - 2);

  fsm_e              state_q, state_n;
  logic              beat_q, beat_n;
  logic              done_q, done_n;
  logic              mis_q, mis_n;
  logic              ill_q, ill_n;
  logic              cap_en;
  acc_mode_t         mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  reg_q;

  logic req_mis, req_ill, last_beat, is_dword;

  // request screening, done on the request inputs before anything is issued
  always_comb begin
    req_mis = 1'b0;
    if (req_size_i == SZ_HALF) req_mis = req_addr_i[0];
    else if (req_size_i == SZ_WORD || req_size_i == SZ_DWORD)
      req_mis = (req_addr_i[OFF_W-1:0] != '0);
    req_ill = (req_size_i == SZ_DWORD) && (req_reg_i[0] || req_reg_i == TOP_PAIR);
  end

  assign is_dword  = (mode_q.size == SZ_DWORD);
  assign last_beat = !is_dword || beat_q;

  // next-state logic
  always_comb begin
    state_n = state_q;
    beat_n  = beat_q;
    done_n  = 1'b0;
    mis_n   = 1'b0;
    ill_n   = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          cap_en = 1'b1;
          mis_n  = req_mis;
          ill_n  = req_ill;
          beat_n = 1'b0;
          if (!(req_mis || req_ill)) state_n = ST_MEM;
        end
      end
      ST_MEM: begin
        if (mem_ready_i) begin
          if (mode_q.store) begin
            if (last_beat) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end else begin
              beat_n = 1'b1;
            end
          end else begin
            state_n = ST_WB;
          end
        end
      end
      ST_WB: begin
        if (wb_ready_i) begin
          if (last_beat) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            beat_n  = 1'b1;
            state_n = ST_MEM;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      done_q  <= 1'b0;
      mis_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      beat_q  <= beat_n;
      done_q  <= done_n;
      mis_q   <= mis_n;
      ill_q   <= ill_n;
    end
  end

  // request capture, clock-enabled datapath registers
  always_ff @(posedge clk) begin
    if (cap_en) begin
      mode_q <= '{store: req_store_i, size: req_size_i, sgn: req_sgn_i, swap: req_swap_i};
      addr_q <= req_addr_i;
      reg_q  <= req_reg_i;
    end
  end

  // outputs
  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_valid_o  = (state_q == ST_MEM);
  assign wb_valid_o   = (state_q == ST_WB);
  assign ld_cap_o     = (state_q == ST_MEM) && mem_ready_i && !mode_q.store;
  assign mem_addr_o   = addr_q + (beat_q ? ADDR_W'(LANES) : '0);
  assign off_o        = addr_q[OFF_W-1:0];
  assign mode_o       = mode_q;
  assign done_o       = done_q;
  assign misaligned_o = mis_q;
  assign illegal_o    = ill_q;

  // pair select: big-endian first beat is the odd register, swap mode flips it
  always_comb begin
    if (is_dword) reg_idx_o = {reg_q[IDX_W-1:1], ~(beat_q ^ mode_q.swap)};
    else          reg_idx_o = reg_q;
  end

endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]            rdata_i,
  input  logic [$clog2(DATA_W/8)-1:0]  off_i,
  input  acc_mode_t                    mode_i,
  output logic [DATA_W-1:0]            data_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);

  logic [7:0]        byte_v;
  logic [15:0]       half_raw, half_v;
  logic [DATA_W-1:0] word_sw;

  // lane k of the bus sits at the most significant end for offset 0
  always_comb begin
    byte_v = '0;
    for (int i = 0; i < LANES; i++)
      if (off_i == OFF_W'(i)) byte_v = rdata_i[DATA_W-1-8*i -: 8];
    half_raw = '0;
    for (int j = 0; j < HALVES; j++)
      if (off_i[OFF_W-1:1] == (OFF_W-1)'(j)) half_raw = rdata_i[DATA_W-1-16*j -: 16];
    half_v = mode_i.swap ? {half_raw[7:0], half_raw[15:8]} : half_raw;
    for (int i = 0; i < LANES; i++)
      word_sw[8*i +: 8] = rdata_i[DATA_W-1-8*i -: 8];
  end

  always_comb begin
    unique case (mode_i.size)
      SZ_BYTE: data_o = {{(DATA_W-8){mode_i.sgn & byte_v[7]}}, byte_v};
      SZ_HALF: data_o = {{(DATA_W-16){mode_i.sgn & half_v[15]}}, half_v};
      default: data_o = mode_i.swap ? word_sw : rdata_i;
    endcase
  end

endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]            src_i,
  input  logic [$clog2(DATA_W/8)-1:0]  off_i,
  input  acc_mode_t                    mode_i,
  output logic [DATA_W-1:0]            wdata_o,
  output logic [DATA_W/8-1:0]          be_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);

  logic [15:0]       half_v;
  logic [DATA_W-1:0] word_sw;

  always_comb begin
    half_v = mode_i.swap ? {src_i[7:0], src_i[15:8]} : src_i[15:0];
    for (int i = 0; i < LANES; i++)
      word_sw[8*i +: 8] = src_i[DATA_W-1-8*i -: 8];
    unique case (mode_i.size)
      SZ_BYTE: wdata_o = {LANES{src_i[7:0]}};
      SZ_HALF: wdata_o = {HALVES{half_v}};
      default: wdata_o = mode_i.swap ? word_sw : src_i;
    endcase
  end

  // one enable per lane; lane g carries address offset g (most significant first)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit_byte, hit_half;
    assign hit_byte = (mode_i.size == SZ_BYTE) && (off_i == OFF_W'(g));
    assign hit_half = (mode_i.size == SZ_HALF) && (off_i[OFF_W-1:1] == (OFF_W-1)'(g / 2));
    assign be_o[LANES-1-g] = hit_byte || hit_half ||
                             (mode_i.size == SZ_WORD) || (mode_i.size == SZ_DWORD);
  end

endmodule

// File: rtl/ldst_fmt.sv
module ldst_fmt
  import ldst_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_store,
  input  logic [1:0]                 req_size,
  input  logic                       req_signed,
  input  logic                       req_swap,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [$clog2(REG_CNT)-1:0] req_reg,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W/8-1:0]        mem_be,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [$clog2(REG_CNT)-1:0] rf_rd_idx,
  input  logic [DATA_W-1:0]          rf_rd_data,
  output logic                       rf_wr_valid,
  input  logic                       rf_wr_ready,
  output logic [$clog2(REG_CNT)-1:0] rf_wr_idx,
  output logic [DATA_W-1:0]          rf_wr_data,
  output logic                       done,
  output logic                       misaligned,
  output logic                       illegal
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = $clog2(REG_CNT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_mode_t         mode;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  reg_idx;
  logic              ld_cap;
  logic [DATA_W-1:0] ld_fmt;
  logic [DATA_W-1:0] wb_data_q, wb_data_n;

  ldst_ctrl #(
    .ADDR_W (ADDR_W),
    .REG_CNT(REG_CNT),
    .LANES  (LANES)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid_i (req_valid),
    .req_store_i (req_store),
    .req_size_i  (acc_size_e'(req_size)),
    .req_sgn_i   (req_signed),
    .req_swap_i  (req_swap),
    .req_addr_i  (req_addr),
    .req_reg_i   (req_reg),
    .mem_ready_i (mem_ready),
    .wb_ready_i  (rf_wr_ready),
    .req_ready_o (req_ready),
    .mem_valid_o (mem_valid),
    .wb_valid_o  (rf_wr_valid),
    .mem_addr_o  (mem_addr),
    .reg_idx_o   (reg_idx),
    .mode_o      (mode),
    .off_o       (off),
    .ld_cap_o    (ld_cap),
    .done_o      (done),
    .misaligned_o(misaligned),
    .illegal_o   (illegal)
  );

  ldst_load_fmt #(.DATA_W(DATA_W)) load_i (
    .rdata_i(mem_rdata),
    .off_i  (off),
    .mode_i (mode),
    .data_o (ld_fmt)
  );

  ldst_store_fmt #(.DATA_W(DATA_W)) store_i (
    .src_i  (rf_rd_data),
    .off_i  (off),
    .mode_i (mode),
    .wdata_o(mem_wdata),
    .be_o   (mem_be)
  );

  // writeback holding register: next-state and register kept apart
  always_comb begin
    wb_data_n = wb_data_q;
    if (ld_cap) wb_data_n = ld_fmt;
  end

  always_ff @(posedge clk) begin
    wb_data_q <= wb_data_n;
  end

  assign mem_we     = mode.store;
  assign rf_rd_idx  = reg_idx;
  assign rf_wr_idx  = reg_idx;
  assign rf_wr_data = wb_data_q;

endmodule

// File: rtl/ldst_fmt_chk.sv
module ldst_fmt_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_CNT = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [1:0]                 req_size,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [$clog2(REG_CNT)-1:0] req_reg,
  input logic                       mem_valid,
  input logic                       mem_ready,
  input logic                       mem_we,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic [DATA_W/8-1:0]        mem_be,
  input logic [DATA_W-1:0]          mem_wdata,
  input logic                       rf_wr_valid,
  input logic                       rf_wr_ready,
  input logic [$clog2(REG_CNT)-1:0] rf_wr_idx,
  input logic [DATA_W-1:0]          rf_wr_data,
  input logic                       done,
  input logic                       misaligned,
  input logic                       illegal
);

  logic acc;
  assign acc = req_valid && req_ready;

  // R10: a stalled memory beat keeps every output steady
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) &&
                                $stable(mem_be) && $stable(mem_wdata));

  // R10: a stalled writeback keeps index and data steady
  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid && !rf_wr_ready |=> rf_wr_valid && $stable(rf_wr_idx) && $stable(rf_wr_data));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: no request is taken while a beat or writeback is outstanding
  a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !rf_wr_valid);

  // R9: an odd halfword address is flagged and never reaches memory
  a_r9_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_size == 2'd1 && req_addr[0] |=> misaligned && !mem_valid && !done);

  // R8: an odd register in a doubleword request is flagged and never reaches memory
  a_r8_odd_pair: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_size == 2'd3 && req_reg[0] |=> illegal && !mem_valid && !done);

  // R6: a memory beat always enables at least one lane
  a_r6_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $countones(mem_be) != 0);

  // R7: a doubleword second beat follows the first at the next word address
  a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we && $past(mem_valid && mem_ready && mem_we) &&
    $past(mem_be) == {(DATA_W/8){1'b1}} && mem_be == {(DATA_W/8){1'b1}}
    |-> mem_addr == $past(mem_addr) + ADDR_W'(DATA_W/8));

endmodule

bind ldst_fmt ldst_fmt_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .REG_CNT(REG_CNT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .req_reg    (req_reg),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .rf_wr_valid(rf_wr_valid),
  .rf_wr_ready(rf_wr_ready),
  .rf_wr_idx  (rf_wr_idx),
  .rf_wr_data (rf_wr_data),
  .done       (done),
  .misaligned (misaligned),
  .illegal    (illegal)
);

// File: tb/ldst_fmt_tb_top.sv
module ldst_fmt_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LD_N = 14;

  // {addr[7:0], size[1:0], signed, swap, expected[31:0]}
  localparam logic [43:0] LD_VEC [0:LD_N-1] = '{
    {8'h00, 2'd0, 1'b1, 1'b0, 32'hFFFF_FFA1},
    {8'h01, 2'd0, 1'b0, 1'b0, 32'h0000_0072},
    {8'h01, 2'd0, 1'b1, 1'b0, 32'h0000_0072},
    {8'h02, 2'd0, 1'b1, 1'b0, 32'hFFFF_FF83},
    {8'h03, 2'd0, 1'b0, 1'b0, 32'h0000_00F4},
    {8'h03, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFF4},
    {8'h06, 2'd0, 1'b1, 1'b0, 32'h0000_0033},
    {8'h00, 2'd1, 1'b1, 1'b0, 32'hFFFF_A172},
    {8'h02, 2'd1, 1'b0, 1'b0, 32'h0000_83F4},
    {8'h02, 2'd1, 1'b1, 1'b1, 32'hFFFF_F483},
    {8'h00, 2'd1, 1'b0, 1'b1, 32'h0000_72A1},
    {8'h04, 2'd1, 1'b1, 1'b0, 32'h0000_1122},
    {8'h00, 2'd2, 1'b0, 1'b0, 32'hA172_83F4},
    {8'h00, 2'd2, 1'b1, 1'b1, 32'hF483_72A1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_swap = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_reg = '0;
  logic        req_ready, mem_valid, mem_ready, mem_we, rf_wr_valid, rf_wr_ready;
  logic        done, misaligned, illegal;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
  logic [3:0]  mem_be, rf_rd_idx, rf_wr_idx;

  logic        stall_en = 1'b0;
  logic        pl_en = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [31:0] pl_data = '0;

  logic [31:0] rf [0:15];
  logic [31:0] cyc = '0;
  int          n_mem = 0, n_wr = 0, n_done = 0, n_st = 0;
  logic [31:0] st_data [0:3];
  logic [31:0] st_addr [0:3];
  logic [3:0]  st_be   [0:3];

  int n_chk = 0, n_err = 0;
  int s_mem, s_wr, s_done, s_st;
  logic seen_mis, seen_ill, ready_mid;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a[5:2])
      4'd0:    mem_word = 32'hA172_83F4;
      4'd1:    mem_word = 32'h1122_3344;
      4'd2:    mem_word = 32'h5566_7788;
      4'd3:    mem_word = 32'h99AA_BBCC;
      default: mem_word = {a[7:0], a[7:0], ~a[7:0], 8'h5A};
    endcase
  endfunction

  assign mem_rdata   = mem_word(mem_addr);
  assign mem_ready   = !stall_en || (cyc[1:0] == 2'b11);
  assign rf_wr_ready = !stall_en || cyc[0];
  assign rf_rd_data  = rf[rf_rd_idx];

  ldst_fmt dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_swap(req_swap),
    .req_addr(req_addr), .req_reg(req_reg),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_valid(rf_wr_valid), .rf_wr_ready(rf_wr_ready),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .done(done), .misaligned(misaligned), .illegal(illegal)
  );

  // bench-side register file, memory monitor and event counters
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pl_en) rf[pl_idx] <= pl_data;
    else if (rf_wr_valid && rf_wr_ready) rf[rf_wr_idx] <= rf_wr_data;
    if (rf_wr_valid && rf_wr_ready) n_wr <= n_wr + 1;
    if (done) n_done <= n_done + 1;
    if (mem_valid && mem_ready) begin
      n_mem <= n_mem + 1;
      if (mem_we) begin
        st_data[n_st % 4] <= mem_wdata;
        st_addr[n_st % 4] <= mem_addr;
        st_be[n_st % 4]   <= mem_be;
        n_st <= n_st + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run(input logic st, input logic [1:0] sz, input logic sg, input logic sw,
                     input logic [31:0] a, input logic [3:0] r);
    @(negedge clk);
    s_mem = n_mem; s_wr = n_wr; s_done = n_done; s_st = n_st;
    req_store = st; req_size = sz; req_signed = sg; req_swap = sw;
    req_addr = a; req_reg = r; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ready_mid = req_ready;
    seen_mis = 1'b0; seen_ill = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (misaligned) seen_mis = 1'b1;
      if (illegal) seen_ill = 1'b1;
      if (done || misaligned || illegal) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk + 1, n_err + 1);
    $finish;
  end

  initial begin
    logic [43:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle after reset
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 mem_valid/rf_wr_valid", {30'd0, mem_valid, rf_wr_valid}, 32'd0);
    chk("R1 done/misaligned/illegal", {29'd0, done, misaligned, illegal}, 32'd0);

    // R2 R3 R4 R5: load table, stalls on odd entries
    for (int i = 0; i < LD_N; i++) begin
      v = LD_VEC[i];
      stall_en = 1'b0;
      preload(4'd3, 32'h0BAD_CAFE);
      stall_en = i[0];
      run(1'b0, v[35:34], v[33], v[32], {24'h0, v[43:36]}, 4'd3);
      if (v[32] && v[35:34] != 2'd0)
        chk($sformatf("R5 swapped load vec %0d", i), rf[3], v[31:0]);
      else if (v[35:34] == 2'd0)
        chk($sformatf("R2 byte load vec %0d", i), rf[3], v[31:0]);
      else if (v[35:34] == 2'd1)
        chk($sformatf("R3 half load vec %0d", i), rf[3], v[31:0]);
      else
        chk($sformatf("R4 word load vec %0d", i), rf[3], v[31:0]);
      chk($sformatf("R11 one done per load vec %0d", i), n_done - s_done, 32'd1);
    end
    stall_en = 1'b0;

    // R6: stores
    preload(4'd5, 32'h1234_56C9);
    run(1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0042, 4'd5);
    chk("R6 byte store be", {28'd0, st_be[s_st % 4]}, 32'h2);
    chk("R6 byte store lane", {24'd0, st_data[s_st % 4][15:8]}, 32'hC9);
    run(1'b1, 2'd0, 1'b0, 1'b0, 32'h0000_0040, 4'd5);
    chk("R6 byte store offset 0 be", {28'd0, st_be[s_st % 4]}, 32'h8);
    run(1'b1, 2'd1, 1'b0, 1'b1, 32'h0000_0042, 4'd5);
    chk("R6 half store be", {28'd0, st_be[s_st % 4]}, 32'h3);
    chk("R5 swapped half store lane", {16'd0, st_data[s_st % 4][15:0]}, 32'hC956);
    run(1'b1, 2'd1, 1'b0, 1'b0, 32'h0000_0040, 4'd5);
    chk("R6 half store offset 0 be", {28'd0, st_be[s_st % 4]}, 32'hC);
    chk("R6 half store offset 0 lane", {16'd0, st_data[s_st % 4][31:16]}, 32'h56C9);
    stall_en = 1'b1;
    run(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_0044, 4'd5);
    stall_en = 1'b0;
    chk("R6 word store be", {28'd0, st_be[s_st % 4]}, 32'hF);
    chk("R10 word store data under stall", st_data[s_st % 4], 32'h1234_56C9);
    chk("R10 one beat per word", n_mem - s_mem, 32'd1);
    run(1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_0044, 4'd5);
    chk("R5 swapped word store", st_data[s_st % 4], 32'hC956_3412);

    // R7: doubleword loads
    stall_en = 1'b1;
    run(1'b0, 2'd3, 1'b0, 1'b0, 32'h0000_0008, 4'd6);
    stall_en = 1'b0;
    chk("R7 dword load high reg", rf[7], 32'h5566_7788);
    chk("R7 dword load low reg", rf[6], 32'h99AA_BBCC);
    chk("R7 dword load two beats", n_mem - s_mem, 32'd2);
    chk("R7 dword load two writebacks", n_wr - s_wr, 32'd2);
    chk("R11 dword load done once", n_done - s_done, 32'd1);
    chk("R12 busy during dword", {31'd0, ready_mid}, 32'd0);
    run(1'b0, 2'd3, 1'b0, 1'b1, 32'h0000_0008, 4'd4);
    chk("R7 swapped dword even reg", rf[4], 32'h8877_6655);
    chk("R7 swapped dword odd reg", rf[5], 32'hCCBB_AA99);

    // R7: doubleword stores
    preload(4'd8, 32'h1357_9BDF);
    preload(4'd9, 32'h0BAD_F00D);
    run(1'b1, 2'd3, 1'b0, 1'b0, 32'h0000_0010, 4'd8);
    chk("R7 dword store first beat data", st_data[s_st % 4], 32'h0BAD_F00D);
    chk("R7 dword store second beat data", st_data[(s_st + 1) % 4], 32'h1357_9BDF);
    chk("R7 dword store first addr", st_addr[s_st % 4], 32'h10);
    chk("R7 dword store second addr", st_addr[(s_st + 1) % 4], 32'h14);
    chk("R11 dword store done once", n_done - s_done, 32'd1);
    run(1'b1, 2'd3, 1'b0, 1'b1, 32'h0000_0010, 4'd8);
    chk("R7 swapped dword store first", st_data[s_st % 4], 32'hDF9B_5713);
    chk("R7 swapped dword store second", st_data[(s_st + 1) % 4], 32'h0DF0_AD0B);

    // R8: illegal pairs
    preload(4'd3, 32'h0BAD_CAFE);
    run(1'b0, 2'd3, 1'b0, 1'b0, 32'h0000_0000, 4'd3);
    chk("R8 odd pair flag", {31'd0, seen_ill}, 32'd1);
    chk("R8 odd pair no beat", n_mem - s_mem, 32'd0);
    chk("R8 odd pair no write", rf[3], 32'h0BAD_CAFE);
    chk("R8 odd pair no done", n_done - s_done, 32'd0);
    run(1'b1, 2'd3, 1'b0, 1'b0, 32'h0000_0000, 4'd14);
    chk("R8 top pair flag", {31'd0, seen_ill}, 32'd1);
    chk("R8 top pair no beat", n_mem - s_mem, 32'd0);

    // R9: misalignment
    run(1'b0, 2'd1, 1'b0, 1'b0, 32'h0000_0001, 4'd3);
    chk("R9 odd half flag", {31'd0, seen_mis}, 32'd1);
    chk("R9 odd half no beat", n_mem - s_mem, 32'd0);
    chk("R9 odd half no write", rf[3], 32'h0BAD_CAFE);
    run(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_0002, 4'd5);
    chk("R9 word offset 2 flag", {31'd0, seen_mis}, 32'd1);
    chk("R9 word offset 2 no beat", n_mem - s_mem, 32'd0);
    run(1'b0, 2'd3, 1'b0, 1'b0, 32'h0000_0006, 4'd6);
    chk("R9 dword offset 2 flag", {31'd0, seen_mis}, 32'd1);
    chk("R9 dword no done", n_done - s_done, 32'd0);
    chk("R12 ready after reject", {31'd0, req_ready}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule